// File: doc/BRIEF.md
# Low-Power Mode Wake Sequencer

This block decides when a microcontroller leaves its running state, how far it powers down, and in what order it comes back. Software asks for a target mode with a one-cycle request. The block then drives the enables for the CPU clock, the internal RC oscillator, the flash macro and the core logic regulator. Wake events bring it back: a general interrupt, an RTC alarm or an external reset line. Oscillator start-up, the short SRAM-run delay and the flash start-up delay are all measured on a free-running reference tick. That tick stands for one cycle of the 4 MHz internal oscillator.

The block releases the CPU and the flash separately. The CPU may execute from SRAM a few oscillator cycles after the oscillator has settled. Flash stays blocked until a longer timer, started at the same moment, has expired. Leaving deep power-down counts as a full reset. The regulator comes back first, a synchronous reset output is held for a set number of clocks, and then the oscillator and flash sequence runs. A wake event that arrives while power-down is being entered is held and acted on as soon as entry finishes.

Top module: `lpw_seq`

## Requirements
- R1: While the reset input is low, reg_en and sys_rst are 1. osc_en, flash_en, cpu_clk_en, cpu_release and flash_release are 0, and mode_status is 3. After reset the block runs the deep power-down wake sequence (R8 to R10).
- R2: A request (req_valid=1) is decoded from req_mode as follows. Code 1 enters sleep on the next cycle: mode_status becomes 1 and cpu_clk_en becomes 0, while osc_en and flash_en stay 1. Code 2 starts power-down entry and code 3 starts deep power-down entry. Code 0 changes nothing.
- R3: A request is ignored unless mode_status is 0 and flash_release is 1. In particular it is ignored between CPU release and flash release, and it is ignored during sleep.
- R4: In sleep, a pulse on wake_irq, wake_rtc or wake_ext returns the block to run on the next cycle: mode_status becomes 0 and cpu_clk_en becomes 1.
- R5: Entry lasts ENTRY_CYCLES clocks. During entry cpu_clk_en, cpu_release and flash_release are 0, and osc_en and flash_en are still 1. Once entry ends, power-down has osc_en=0, flash_en=0 and reg_en=1. Deep power-down also drops reg_en to 0. Whenever reg_en is 0, osc_en, flash_en, cpu_release and sys_rst are 0.
- R6: In power-down, any of the three wake inputs sets osc_en on the next cycle.
- R7: In deep power-down only wake_rtc or wake_ext wake the block. A wake_irq pulse leaves reg_en at 0 and mode_status at 3.
- R8: Waking from deep power-down raises reg_en and sys_rst together. sys_rst stays high for exactly RST_CYCLES clocks, and osc_en rises on the cycle it falls.
- R9: cpu_release and cpu_clk_en rise, and mode_status returns to 0, at the clock edge that samples the (OSC_TICKS+SRAM_TICKS)-th ref_tick counted from the rise of osc_en.
- R10: flash_release rises at the clock edge that samples the (OSC_TICKS+FLASH_TICKS)-th ref_tick counted from the rise of osc_en. flash_release is never 1 while cpu_release, osc_en or flash_en is 0.
- R11: A qualifying wake pulse seen during entry, up to and including the last entry cycle, is held. The wake sequence then starts one cycle after entry ends without a further event. During deep entry only wake_rtc and wake_ext qualify.
- R12: mode_status uses these codes: 0 means running, 1 sleep, 2 power-down and 3 deep power-down. Codes 2 and 3 cover entry, the held state and the wake sequence up to CPU release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock pulse per reference oscillator cycle |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| wake_irq | input | 1 | Enabled interrupt wake event |
| wake_rtc | input | 1 | RTC alarm wake event |
| wake_ext | input | 1 | External reset wake event |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_release | output | 1 | CPU may execute from SRAM |
| flash_release | output | 1 | Flash access allowed |
| osc_en | output | 1 | Internal RC oscillator enable |
| flash_en | output | 1 | Flash macro power enable |
| reg_en | output | 1 | Core logic regulator enable |
| sys_rst | output | 1 | Synchronous reset to the core logic |
| mode_status | output | 2 | Current mode code |

## Verification
Two events can fall in the same clock: the end of power-down entry and the arrival of a wake event. The event must be held by the latch in that cycle, while the state moves to the held mode. The bench provokes this on purpose. It pulses a wake input in the middle of entry and again in exactly the last entry cycle. It then expects the held mode to last one cycle, with osc_en low, and osc_en to rise on the next cycle without any further stimulus. For deep entry it checks that an interrupt-only pulse in the same window is dropped.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_ENTER  = 3'd2,
    ST_PD     = 3'd3,
    ST_DPD    = 3'd4,
    ST_REGRST = 3'd5,
    ST_OSCUP  = 3'd6,
    ST_SRAMW  = 3'd7
  } lpw_state_e;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_SLEEP = 2'd1;
  localparam logic [1:0] MODE_PD    = 2'd2;
  localparam logic [1:0] MODE_DPD   = 2'd3;

endpackage

// File: rtl/lpw_rst_sync.sv
module lpw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/lpw_step_timer.sv
// Counts 'step' pulses while 'active' is high. HOLD_DONE selects the output:
// a sticky done flag (1) or a pulse on the final counted step (0).
module lpw_step_timer #(
  parameter int unsigned LIMIT     = 4,
  parameter bit          HOLD_DONE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic step,
  output logic fire
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] CMAX = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          hit;

  assign hit = active && step && !done_q && (cnt_q == CMAX);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!active) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (step && !done_q) begin
      if (hit) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  generate
    if (HOLD_DONE) begin : g_hold
      assign fire = done_q && active;
    end else begin : g_pulse
      assign fire = hit;
    end
  endgenerate

endmodule

// File: rtl/lpw_wake_latch.sv
module lpw_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic evt,
  input  logic clear,
  output logic pend
);

  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (clear) begin
      pend_d = 1'b0;
    end else if (capture && evt) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      pend <= pend_d;
    end
  end

endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
  import lpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake_irq,
  input  logic       wake_rtc,
  input  logic       wake_ext,
  input  logic       pend,
  input  logic       ent_last,
  input  logic       rst_last,
  input  logic       osc_last,
  input  logic       sram_last,
  input  logic       flash_done,
  output lpw_state_e state_q,
  output logic       deep_q,
  output logic       flash_arm_q,
  output logic       cpu_clk_en,
  output logic       cpu_release,
  output logic       flash_release,
  output logic       osc_en,
  output logic       flash_en,
  output logic       reg_en,
  output logic       sys_rst,
  output logic [1:0] mode_status
);

  lpw_state_e state_d;
  logic       deep_d, arm_d;
  logic       any_wake, deep_wake, fully_up;
  logic [1:0] held_code;

  assign any_wake  = wake_irq | wake_rtc | wake_ext;
  assign deep_wake = wake_rtc | wake_ext;
  assign fully_up  = flash_arm_q & flash_done;
  assign held_code = deep_q ? MODE_DPD : MODE_PD;

  // next-state
  always_comb begin
    state_d = state_q;
    deep_d  = deep_q;
    arm_d   = flash_arm_q;
    unique case (state_q)
      ST_RUN: begin
        if (req_valid && fully_up) begin
          unique case (req_mode)
            MODE_SLEEP: state_d = ST_SLEEP;
            MODE_PD: begin
              state_d = ST_ENTER;
              deep_d  = 1'b0;
              arm_d   = 1'b0;
            end
            MODE_DPD: begin
              state_d = ST_ENTER;
              deep_d  = 1'b1;
              arm_d   = 1'b0;
            end
            default: state_d = ST_RUN;
          endcase
        end
      end
      ST_SLEEP:  if (any_wake) state_d = ST_RUN;
      ST_ENTER:  if (ent_last) state_d = deep_q ? ST_DPD : ST_PD;
      ST_PD:     if (pend || any_wake) state_d = ST_OSCUP;
      ST_DPD:    if (pend || deep_wake) state_d = ST_REGRST;
      ST_REGRST: if (rst_last) state_d = ST_OSCUP;
      ST_OSCUP: begin
        if (osc_last) begin
          state_d = ST_SRAMW;
          arm_d   = 1'b1;
        end
      end
      ST_SRAMW:  if (sram_last) state_d = ST_RUN;
      default:   state_d = ST_REGRST;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_REGRST;
      deep_q      <= 1'b1;
      flash_arm_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      deep_q      <= deep_d;
      flash_arm_q <= arm_d;
    end
  end

  // outputs decoded from state
  always_comb begin
    cpu_clk_en  = 1'b0;
    cpu_release = 1'b0;
    osc_en      = 1'b1;
    flash_en    = 1'b1;
    reg_en      = 1'b1;
    sys_rst     = 1'b0;
    mode_status = held_code;
    unique case (state_q)
      ST_RUN: begin
        cpu_clk_en  = 1'b1;
        cpu_release = 1'b1;
        mode_status = MODE_RUN;
      end
      ST_SLEEP: begin
        cpu_release = 1'b1;
        mode_status = MODE_SLEEP;
      end
      ST_PD: begin
        osc_en   = 1'b0;
        flash_en = 1'b0;
      end
      ST_DPD: begin
        osc_en      = 1'b0;
        flash_en    = 1'b0;
        reg_en      = 1'b0;
        mode_status = MODE_DPD;
      end
      ST_REGRST: begin
        osc_en      = 1'b0;
        flash_en    = 1'b0;
        sys_rst     = 1'b1;
        mode_status = MODE_DPD;
      end
      default: begin
      end
    endcase
  end

  assign flash_release = fully_up;

endmodule

// File: rtl/lpw_seq.sv
module lpw_seq
  import lpw_pkg::*;
#(
  parameter int unsigned OSC_TICKS    = 240,
  parameter int unsigned SRAM_TICKS   = 4,
  parameter int unsigned FLASH_TICKS  = 400,
  parameter int unsigned ENTRY_CYCLES = 3,
  parameter int unsigned RST_CYCLES   = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       wake_irq,
  input  logic       wake_rtc,
  input  logic       wake_ext,
  output logic       cpu_clk_en,
  output logic       cpu_release,
  output logic       flash_release,
  output logic       osc_en,
  output logic       flash_en,
  output logic       reg_en,
  output logic       sys_rst,
  output logic [1:0] mode_status
);

  logic       rst_n_s;
  lpw_state_e state;
  logic       deep, flash_arm, pend;
  logic       ent_last, rst_last, osc_last, sram_last, flash_done;
  logic       in_enter, in_regrst, in_oscup, in_sramw, in_held;
  logic       qual_evt;

  assign in_enter  = (state == ST_ENTER);
  assign in_regrst = (state == ST_REGRST);
  assign in_oscup  = (state == ST_OSCUP);
  assign in_sramw  = (state == ST_SRAMW);
  assign in_held   = (state == ST_PD) || (state == ST_DPD);
  assign qual_evt  = deep ? (wake_rtc | wake_ext) : (wake_irq | wake_rtc | wake_ext);

  lpw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  lpw_step_timer #(.LIMIT(ENTRY_CYCLES), .HOLD_DONE(1'b0)) u_ent_tmr (
    .clk (clk), .rst_n (rst_n_s), .active (in_enter), .step (1'b1), .fire (ent_last)
  );

  lpw_step_timer #(.LIMIT(RST_CYCLES), .HOLD_DONE(1'b0)) u_rst_tmr (
    .clk (clk), .rst_n (rst_n_s), .active (in_regrst), .step (1'b1), .fire (rst_last)
  );

  lpw_step_timer #(.LIMIT(OSC_TICKS), .HOLD_DONE(1'b0)) u_osc_tmr (
    .clk (clk), .rst_n (rst_n_s), .active (in_oscup), .step (ref_tick), .fire (osc_last)
  );

  lpw_step_timer #(.LIMIT(SRAM_TICKS), .HOLD_DONE(1'b0)) u_sram_tmr (
    .clk (clk), .rst_n (rst_n_s), .active (in_sramw), .step (ref_tick), .fire (sram_last)
  );

  lpw_step_timer #(.LIMIT(FLASH_TICKS), .HOLD_DONE(1'b1)) u_flash_tmr (
    .clk (clk), .rst_n (rst_n_s), .active (flash_arm), .step (ref_tick), .fire (flash_done)
  );

  lpw_wake_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .capture (in_enter),
    .evt     (qual_evt),
    .clear   (in_held),
    .pend    (pend)
  );

  lpw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_mode      (req_mode),
    .wake_irq      (wake_irq),
    .wake_rtc      (wake_rtc),
    .wake_ext      (wake_ext),
    .pend          (pend),
    .ent_last      (ent_last),
    .rst_last      (rst_last),
    .osc_last      (osc_last),
    .sram_last     (sram_last),
    .flash_done    (flash_done),
    .state_q       (state),
    .deep_q        (deep),
    .flash_arm_q   (flash_arm),
    .cpu_clk_en    (cpu_clk_en),
    .cpu_release   (cpu_release),
    .flash_release (flash_release),
    .osc_en        (osc_en),
    .flash_en      (flash_en),
    .reg_en        (reg_en),
    .sys_rst       (sys_rst),
    .mode_status   (mode_status)
  );

endmodule

// File: rtl/lpw_seq_chk.sv
module lpw_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_irq,
  input logic       wake_rtc,
  input logic       wake_ext,
  input logic       cpu_clk_en,
  input logic       cpu_release,
  input logic       flash_release,
  input logic       osc_en,
  input logic       flash_en,
  input logic       reg_en,
  input logic       sys_rst,
  input logic [1:0] mode_status
);

  AST_FLASH_AFTER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    flash_release |-> (cpu_release && osc_en && flash_en)); // R10

  AST_RST_UNDER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> reg_en); // R8

  AST_REG_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (!osc_en && !flash_en && !cpu_release && !sys_rst)); // R5

  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 2'd1 && (wake_irq || wake_rtc || wake_ext)) |=> (mode_status == 2'd0 && cpu_clk_en)); // R4

  AST_SLEEP_KEEPS_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_status == 2'd1) |-> (osc_en && flash_en && !cpu_clk_en)); // R2

  AST_DEEP_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en && $past(!reg_en) && !wake_rtc && !wake_ext) |=> !reg_en); // R7

endmodule

bind lpw_seq lpw_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wake_irq      (wake_irq),
  .wake_rtc      (wake_rtc),
  .wake_ext      (wake_ext),
  .cpu_clk_en    (cpu_clk_en),
  .cpu_release   (cpu_release),
  .flash_release (flash_release),
  .osc_en        (osc_en),
  .flash_en      (flash_en),
  .reg_en        (reg_en),
  .sys_rst       (sys_rst),
  .mode_status   (mode_status)
);

// File: tb/lpw_seq_test.sv
`timescale 1ns/1ps
module lpw_seq_test;

  localparam int OSC   = 240;
  localparam int SRAM  = 4;
  localparam int FLASH = 400;
  localparam int ENTRY = 3;
  localparam int RSTC  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_tick = 1'b0;
  logic req_valid, wake_irq, wake_rtc, wake_ext;
  logic [1:0] req_mode;
  logic cpu_clk_en, cpu_release, flash_release, osc_en, flash_en, reg_en, sys_rst;
  logic [1:0] mode_status;

  int total = 0;
  int fails = 0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  lpw_seq #(
    .OSC_TICKS(OSC), .SRAM_TICKS(SRAM), .FLASH_TICKS(FLASH),
    .ENTRY_CYCLES(ENTRY), .RST_CYCLES(RSTC), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .req_valid(req_valid), .req_mode(req_mode),
    .wake_irq(wake_irq), .wake_rtc(wake_rtc), .wake_ext(wake_ext),
    .cpu_clk_en(cpu_clk_en), .cpu_release(cpu_release), .flash_release(flash_release),
    .osc_en(osc_en), .flash_en(flash_en), .reg_en(reg_en), .sys_rst(sys_rst),
    .mode_status(mode_status)
  );

  // reference tick: one pulse every third clock
  int tph = 0;
  always @(posedge clk) begin
    tph      <= (tph == 2) ? 0 : tph + 1;
    ref_tick <= (tph == 2);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit wakes(input int mode, input int src);
    if (mode == 3) return (src != 0);
    return 1'b1;
  endfunction

  // monitor of the staggered release timing
  int  n_ticks = 0;
  int  rst_len = 0;
  bit  p_cpu = 1'b0, p_fl = 1'b0, p_srst = 1'b0;
  always @(negedge clk) begin
    if (cpu_release && !p_cpu)
      chk(n_ticks == OSC + SRAM, "R9 cpu_release tick count", n_ticks, OSC + SRAM);
    if (flash_release && !p_fl) begin
      chk(n_ticks == OSC + FLASH, "R10 flash_release tick count", n_ticks, OSC + FLASH);
      chk(cpu_release, "R10 cpu released first", cpu_release, 1);
    end
    if (p_srst && !sys_rst && mon_on) begin
      chk(rst_len == RSTC, "R8 sys_rst length", rst_len, RSTC);
      chk(osc_en, "R8 osc_en at sys_rst fall", osc_en, 1);
    end
    if (sys_rst) rst_len++; else rst_len = 0;
    if (!osc_en) n_ticks = 0; else if (ref_tick) n_ticks++;
    p_cpu  = cpu_release;
    p_fl   = flash_release;
    p_srst = sys_rst;
  end

  task automatic request(input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode  = m;
    @(negedge clk);
    req_valid = 1'b0;
    req_mode  = 2'd0;
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    wake_irq = (src == 0);
    wake_rtc = (src == 1);
    wake_ext = (src == 2);
    @(negedge clk);
    wake_irq = 1'b0;
    wake_rtc = 1'b0;
    wake_ext = 1'b0;
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  task automatic wait_cpu();
    while (!cpu_release) @(negedge clk);
  endtask

  task automatic wait_full();
    while (!flash_release) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog R1..", 0, 1);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0;
    wake_irq = 1'b0; wake_rtc = 1'b0; wake_ext = 1'b0;
    idle(4);
    // R1 reset state
    chk(reg_en && sys_rst, "R1 reg_en/sys_rst in reset", {reg_en, sys_rst}, 3);
    chk(!osc_en && !flash_en && !cpu_clk_en, "R1 sources off in reset", {osc_en, flash_en, cpu_clk_en}, 0);
    chk(!cpu_release && !flash_release, "R1 releases low in reset", {cpu_release, flash_release}, 0);
    chk(mode_status == 2'd3, "R1 status in reset", mode_status, 3);
    rst_n = 1'b1;
    wait_full();
    chk(mode_status == 2'd0, "R12 running after cold start", mode_status, 0);
    mon_on = 1'b1;

    // R2 sleep and R4 wake
    request(2'd1);
    chk(mode_status == 2'd1 && !cpu_clk_en, "R2 sleep entered", {mode_status, cpu_clk_en}, 2);
    chk(osc_en && flash_en, "R2 sources kept in sleep", {osc_en, flash_en}, 3);
    request(2'd2);
    chk(mode_status == 2'd1, "R3 request ignored in sleep", mode_status, 1);
    pulse(0);
    chk(mode_status == 2'd0 && cpu_clk_en, "R4 irq wakes sleep", {mode_status, cpu_clk_en}, 1);

    // R2 code 0 no effect
    request(2'd0);
    chk(mode_status == 2'd0 && cpu_clk_en && flash_release, "R2 code 0 ignored", mode_status, 0);

    // R5 power-down entry, R6 wake, R3 request between releases
    request(2'd2);
    for (int i = 0; i < ENTRY; i++) begin
      chk(osc_en && flash_en && !cpu_release && !flash_release && !cpu_clk_en,
          "R5 entry outputs", {osc_en, flash_en, cpu_release, flash_release}, 12);
      chk(mode_status == 2'd2, "R12 status during entry", mode_status, 2);
      @(negedge clk);
    end
    chk(!osc_en && !flash_en && reg_en, "R5 power-down held", {osc_en, flash_en, reg_en}, 1);
    idle(7);
    chk(!osc_en && mode_status == 2'd2, "R6 stays down without event", osc_en, 0);
    pulse(1);
    chk(osc_en, "R6 rtc wakes power-down", osc_en, 1);
    wait_cpu();
    chk(!flash_release, "R10 flash still blocked at cpu release", flash_release, 0);
    request(2'd1);
    chk(mode_status == 2'd0 && cpu_clk_en, "R3 request ignored before flash release", mode_status, 0);
    wait_full();

    // R5/R7/R8 deep power-down
    request(2'd3);
    idle(ENTRY);
    chk(!reg_en && mode_status == 2'd3, "R5 deep drops regulator", reg_en, 0);
    pulse(0);
    idle(10);
    chk(!reg_en && mode_status == 2'd3, "R7 irq ignored in deep", reg_en, 0);
    pulse(2);
    chk(reg_en && sys_rst, "R8 ext wakes deep with reset", {reg_en, sys_rst}, 3);
    wait_full();

    // R11 wake during power-down entry (middle)
    request(2'd2);
    pulse(0);
    @(negedge clk);
    chk(!osc_en, "R11 held state one cycle", osc_en, 0);
    @(negedge clk);
    chk(osc_en, "R11 latched wake mid-entry", osc_en, 1);
    wait_full();

    // R11 wake in the very last entry cycle
    request(2'd2);
    @(negedge clk);
    pulse(2);
    chk(!osc_en, "R11 held after last-cycle event", osc_en, 0);
    @(negedge clk);
    chk(osc_en, "R11 latched wake last entry cycle", osc_en, 1);
    wait_full();

    // R11 deep entry: irq not latched, rtc latched
    request(2'd3);
    pulse(0);
    idle(10);
    chk(!reg_en, "R11 irq not latched in deep entry", reg_en, 0);
    pulse(1);
    wait_full();
    request(2'd3);
    pulse(1);
    @(negedge clk);
    chk(!reg_en, "R11 deep held one cycle", reg_en, 0);
    @(negedge clk);
    chk(reg_en && sys_rst, "R11 latched rtc in deep entry", {reg_en, sys_rst}, 3);
    wait_full();

    // constrained random mix
    for (int it = 0; it < 14; it++) begin
      int kind = int'($urandom_range(0, 3));
      int src  = int'($urandom_range(0, 2));
      int gap  = int'($urandom_range(0, 6));
      case (kind)
        0: begin
          request(2'd1);
          idle(gap);
          pulse(src);
          chk(mode_status == 2'd0 && cpu_clk_en, "R4 random sleep wake", mode_status, 0);
        end
        1: begin
          request(2'd2);
          idle(ENTRY + gap);
          chk(!osc_en && !flash_en, "R5 random power-down", {osc_en, flash_en}, 0);
          pulse(src);
          chk(osc_en == wakes(2, src), "R6 random power-down wake", osc_en, wakes(2, src));
          wait_full();
        end
        2: begin
          request(2'd3);
          idle(ENTRY + gap);
          chk(!reg_en, "R5 random deep", reg_en, 0);
          pulse(src);
          if (wakes(3, src)) begin
            chk(reg_en && sys_rst, "R8 random deep wake", {reg_en, sys_rst}, 3);
          end else begin
            idle(6);
            chk(!reg_en, "R7 random irq in deep", reg_en, 0);
            pulse(2);
          end
          wait_full();
        end
        default: begin
          request(2'd0);
          pulse(src);
          chk(mode_status == 2'd0 && cpu_clk_en && osc_en && flash_release,
              "R2 random idle code", mode_status, 0);
        end
      endcase
    end

    idle(4);
    summary();
    $finish;
  end

endmodule